// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block drains a byte-addressed sector buffer toward whoever asked for the data. It runs in one of two ways. In host mode a reader pulls one 16-bit word per strobe and gets it back on a data port. In DMA mode one request pulse moves a chunk of words into one of three destination memories. These are a shared work RAM, which can be split into two banks or used whole, a program RAM, and a sample RAM for the sound unit. Each destination takes its own address scaling and its own byte order.

The engine keeps the transfer state: a 16-bit buffer address counter, a signed 16-bit remaining-byte counter, a busy flag and a 3-bit destination selector. A separate register block loads them with a start pulse. When the byte counter runs out, an end-of-transfer sequence updates the status flags. It can also pull the transfer-end status bit low and raise a level-5 interrupt request. The buffer is read through a byte-wide synchronous port with one cycle of latency. The destinations are written through one 16-bit write port that carries a target code.

Requests are taken only while the internal sequencer is idle. A start pulse wins over a host read, and a host read wins over a DMA request in the same cycle. A request that arrives while the sequencer is busy is dropped.

Top module: `sbx_engine`

## Requirements
- R1: After reset the busy, end, data-ready and interrupt outputs are 0, the idle status flag and the active-low transfer-end flag are 1, and the address counter, byte counter and DMA address are 0.
- R2: An honoured host read returns the buffer byte at the address counter in bits 15:8 and the byte at counter+1 in bits 7:0. The address counter then advances by 2 (modulo 65536) and the byte counter drops by 2.
- R3: A host read is honoured only while busy is 1 and the selector is 3 for a sub-side reader (rd_sub_i=1) or 2 for a main-side reader (rd_sub_i=0). Any other read answers with data 0 one cycle later and changes no counter or flag.
- R4: When a host read leaves the byte counter at 0 or below (signed), or a DMA step is the last one, the end sequence runs. It sets the byte counter to 0, busy to 0, the end flag to 1, data-ready to 0 and the idle status flag to 1.
- R5: In the end sequence, dte_ie_i=1 drives the active-low transfer-end flag to 0. If irq_mask5_i is also 1, irq5_o pulses high for one cycle.
- R6: A DMA step writes 256 words when the signed byte counter is above 512. Otherwise it writes (count+1)/2 words (none when count is 0 or below), and this is the last step.
- R7: The destination byte offset of a step's first word comes from the DMA address A. Selector 7 with word_split_i=1 gives target code 0, offset (A AND 0x3FFF)*8 and bank = NOT bank_mode_i. Selector 7 with word_split_i=0 gives code 1, offset (A AND 0x7FFF)*8. Selector 5 gives code 2, offset A*8. Selector 4 gives code 3, offset (A AND 0x3FF)*4. Each later word of the step adds 2 to the offset.
- R8: For target codes 0 to 2 a DMA word carries the first buffer byte in bits 15:8. For code 3 the first buffer byte is in bits 7:0.
- R9: After a DMA step the address counter advances by twice the word count (modulo 65536). The DMA address advances by the step's byte count divided by 8, or by 4 for code 3 (truncating). A non-last step lowers the byte counter by its byte count.
- R10: A DMA request while busy is 0 or with a selector other than 4, 5 or 7 returns done one cycle later with no write and no change to any counter.
- R11: A start pulse loads the address counter, byte counter, selector and DMA address, sets busy and data-ready to 1, and clears the end flag and the idle status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load transfer state and begin a transfer |
| ld_dac_i | input | 16 | Initial buffer address counter |
| ld_cnt_i | input | 16 | Initial byte counter (signed) |
| ld_sel_i | input | 3 | Destination selector |
| ld_dma_addr_i | input | 16 | Initial DMA destination address |
| word_split_i | input | 1 | Work RAM is split into two banks |
| bank_mode_i | input | 1 | Bank mode bit; split bank written is its inverse |
| dte_ie_i | input | 1 | Transfer-end interrupt enable |
| irq_mask5_i | input | 1 | Level-5 interrupt mask bit |
| rd_i | input | 1 | Host word read strobe |
| rd_sub_i | input | 1 | Reader is the sub side (1) or main side (0) |
| rd_valid_o | output | 1 | Host read data valid, one cycle |
| rd_data_o | output | 16 | Host read data |
| dma_req_i | input | 1 | Start one DMA step |
| dma_done_o | output | 1 | DMA step finished, one cycle |
| buf_addr_o | output | BUF_AW | Sector buffer byte address |
| buf_rdata_i | input | 8 | Sector buffer read byte, one cycle after address |
| dst_we_o | output | 1 | Destination word write strobe |
| dst_tgt_o | output | 2 | Target code 0 split work, 1 full work, 2 program, 3 sample |
| dst_bank_o | output | 1 | Bank of split work RAM |
| dst_addr_o | output | 19 | Destination byte offset |
| dst_wdata_o | output | 16 | Destination write word |
| dac_o | output | 16 | Buffer address counter |
| cnt_o | output | 16 | Byte counter |
| dma_addr_o | output | 16 | DMA destination address |
| busy_o | output | 1 | Transfer in progress |
| end_o | output | 1 | Transfer ended flag |
| ready_o | output | 1 | Data-ready flag |
| idle_flag_o | output | 1 | Interface status: no transfer in progress |
| dte_n_o | output | 1 | Interface status: transfer-end, active low |
| irq5_o | output | 1 | Level-5 interrupt request pulse |

## Verification
A stale or mis-stepped address counter shows up as a wrong data word on the very next host read or DMA write. A wrong byte counter shows up at the boundary, where a transfer ends one read or one step early or late, with busy, end and the interrupt pulse all moving on the wrong strobe. A wrong destination mapping or word order corrupts the first write of a step. A bad DMA address update shows up as a wrong base on the next step and can be read on dma_addr_o as soon as done rises.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int DST_AW = 19;

    localparam logic [2:0] SEL_MAIN = 3'd2;
    localparam logic [2:0] SEL_SUB  = 3'd3;
    localparam logic [2:0] SEL_PCM  = 3'd4;
    localparam logic [2:0] SEL_PRG  = 3'd5;
    localparam logic [2:0] SEL_WORK = 3'd7;

    typedef enum logic [1:0] {
        TGT_WSPLIT = 2'd0,
        TGT_WFULL  = 2'd1,
        TGT_PRG    = 2'd2,
        TGT_PCM    = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_HI, SQ_LO, SQ_CM, SQ_FIN
    } seq_e;

    typedef struct packed {
        logic              ok;
        tgt_e              tgt;
        logic              bank;
        logic [DST_AW-1:0] off;
    } route_t;

    // Selector and DMA address to target, bank and byte offset.
    function automatic route_t route_of(input logic [2:0] sel, input logic split,
                                        input logic mode0, input logic [15:0] a);
        route_t r;
        r = '0;
        case (sel)
            SEL_WORK: begin
                r.ok = 1'b1;
                if (split) begin
                    r.tgt  = TGT_WSPLIT;
                    r.bank = ~mode0;
                    r.off  = {2'b00, a[13:0], 3'b000};
                end else begin
                    r.tgt = TGT_WFULL;
                    r.off = {1'b0, a[14:0], 3'b000};
                end
            end
            SEL_PRG: begin
                r.ok  = 1'b1;
                r.tgt = TGT_PRG;
                r.off = {a, 3'b000};
            end
            SEL_PCM: begin
                r.ok  = 1'b1;
                r.tgt = TGT_PCM;
                r.off = {7'd0, a[9:0], 2'b00};
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    // Sample RAM keeps buffer order in the low lane; the others are big-endian.
    function automatic logic [15:0] order_word(input tgt_e t, input logic [7:0] first,
                                               input logic [7:0] second);
        return (t == TGT_PCM) ? {second, first} : {first, second};
    endfunction

    function automatic logic [15:0] step_adv(input tgt_e t, input logic [9:0] nbytes);
        return (t == TGT_PCM) ? {8'd0, nbytes[9:2]} : {9'd0, nbytes[9:3]};
    endfunction

endpackage

// File: rtl/sbx_dest_map.sv
module sbx_dest_map
    import sbx_pkg::*;
(
    input  logic [2:0]  sel,
    input  logic        split,
    input  logic        mode0,
    input  logic [15:0] dma_addr,
    input  tgt_e        adv_tgt,
    input  logic [9:0]  adv_bytes,
    output route_t      route,
    output logic [15:0] adv
);
    always_comb begin
        route = route_of(sel, split, mode0, dma_addr);
        adv   = step_adv(adv_tgt, adv_bytes);
    end
endmodule

// File: rtl/sbx_fetch_seq.sv
module sbx_fetch_seq
    import sbx_pkg::*;
#(
    parameter int BUF_AW     = 14,
    parameter int STEP_WORDS = 256,
    localparam int IDX_W     = $clog2(STEP_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_host,
    input  logic              go_dma,
    input  logic [IDX_W-1:0]  n_words,
    input  logic [15:0]       base,
    input  logic [7:0]        buf_rdata,
    output logic [BUF_AW-1:0] buf_addr,
    output seq_e              state,
    output logic              is_dma,
    output logic [IDX_W-1:0]  idx,
    output logic [15:0]       word
);
    localparam logic [IDX_W-1:0] IDX_ONE = 1;

    logic [IDX_W-1:0] nw_q;
    logic [7:0]       hi_q;
    logic [15:0]      byte_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            is_dma <= 1'b0;
            idx    <= '0;
            nw_q   <= '0;
            hi_q   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    idx <= '0;
                    if (go_host) begin
                        is_dma <= 1'b0;
                        state  <= SQ_HI;
                    end else if (go_dma) begin
                        is_dma <= 1'b1;
                        nw_q   <= n_words;
                        state  <= (n_words == '0) ? SQ_FIN : SQ_HI;
                    end
                end
                SQ_HI: state <= SQ_LO;
                SQ_LO: begin
                    hi_q  <= buf_rdata;
                    state <= SQ_CM;
                end
                SQ_CM: begin
                    if (!is_dma)                   state <= SQ_IDLE;
                    else if (idx == nw_q - IDX_ONE) state <= SQ_FIN;
                    else begin
                        idx   <= idx + IDX_ONE;
                        state <= SQ_HI;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        byte_addr = base + {7'd0, idx, 1'b0} + {15'd0, state == SQ_LO};
        buf_addr  = byte_addr[BUF_AW-1:0];
        word      = {hi_q, buf_rdata};
    end
endmodule

// File: rtl/sbx_engine.sv
module sbx_engine
    import sbx_pkg::*;
#(
    parameter int BUF_AW     = 14,
    parameter int STEP_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [15:0]       ld_dac_i,
    input  logic [15:0]       ld_cnt_i,
    input  logic [2:0]        ld_sel_i,
    input  logic [15:0]       ld_dma_addr_i,
    input  logic              word_split_i,
    input  logic              bank_mode_i,
    input  logic              dte_ie_i,
    input  logic              irq_mask5_i,
    input  logic              rd_i,
    input  logic              rd_sub_i,
    output logic              rd_valid_o,
    output logic [15:0]       rd_data_o,
    input  logic              dma_req_i,
    output logic              dma_done_o,
    output logic [BUF_AW-1:0] buf_addr_o,
    input  logic [7:0]        buf_rdata_i,
    output logic              dst_we_o,
    output logic [1:0]        dst_tgt_o,
    output logic              dst_bank_o,
    output logic [18:0]       dst_addr_o,
    output logic [15:0]       dst_wdata_o,
    output logic [15:0]       dac_o,
    output logic [15:0]       cnt_o,
    output logic [15:0]       dma_addr_o,
    output logic              busy_o,
    output logic              end_o,
    output logic              ready_o,
    output logic              idle_flag_o,
    output logic              dte_n_o,
    output logic              irq5_o
);
    localparam int IDX_W      = $clog2(STEP_WORDS + 1);
    localparam int STEP_BYTES = 2 * STEP_WORDS;

    logic [2:0]  sel_q;
    seq_e        st;
    logic        seq_dma;
    logic [IDX_W-1:0] idx;
    logic [15:0] word;
    route_t      route;
    logic [15:0] adv;

    logic        step_last_q, step_bank_q;
    tgt_e        step_tgt_q;
    logic [DST_AW-1:0] step_off_q;
    logic [IDX_W-1:0]  step_nw_q, nw_c;
    logic        last_c;

    logic idle, rd_take, rd_ok, go_host, dma_take, dma_ok, go_dma, start_take;
    logic commit_host, finish_dma, do_end, host_under;
    logic [15:0] cnt_dec, step_bytes;

    sbx_dest_map u_map (
        .sel(sel_q), .split(word_split_i), .mode0(bank_mode_i), .dma_addr(dma_addr_o),
        .adv_tgt(step_tgt_q), .adv_bytes({step_nw_q, 1'b0}), .route(route), .adv(adv)
    );

    sbx_fetch_seq #(.BUF_AW(BUF_AW), .STEP_WORDS(STEP_WORDS)) u_seq (
        .clk(clk), .rst(rst), .go_host(go_host), .go_dma(go_dma), .n_words(nw_c),
        .base(dac_o), .buf_rdata(buf_rdata_i), .buf_addr(buf_addr_o), .state(st),
        .is_dma(seq_dma), .idx(idx), .word(word)
    );

    always_comb begin
        idle       = (st == SQ_IDLE);
        start_take = start_i & idle;
        rd_take    = rd_i & idle & ~start_i;
        rd_ok      = busy_o & (rd_sub_i ? (sel_q == SEL_SUB) : (sel_q == SEL_MAIN));
        go_host    = rd_take & rd_ok;
        dma_take   = dma_req_i & idle & ~start_i & ~rd_i;
        dma_ok     = busy_o & route.ok;
        go_dma     = dma_take & dma_ok;

        if (!cnt_o[15] && cnt_o > 16'(STEP_BYTES)) begin
            nw_c = IDX_W'(STEP_WORDS);  last_c = 1'b0;
        end else if (!cnt_o[15] && cnt_o != 16'd0) begin
            nw_c = IDX_W'((cnt_o + 16'd1) >> 1);  last_c = 1'b1;
        end else begin
            nw_c = '0;  last_c = 1'b1;
        end

        commit_host = (st == SQ_CM) & ~seq_dma;
        finish_dma  = (st == SQ_FIN);
        cnt_dec     = cnt_o - 16'd2;
        host_under  = cnt_dec[15] | (cnt_dec == 16'd0);
        step_bytes  = 16'({step_nw_q, 1'b0});
        do_end      = (commit_host & host_under) | (finish_dma & step_last_q);

        dst_we_o    = (st == SQ_CM) & seq_dma;
        dst_tgt_o   = step_tgt_q;
        dst_bank_o  = step_bank_q;
        dst_addr_o  = step_off_q + {{(DST_AW-IDX_W-1){1'b0}}, idx, 1'b0};
        dst_wdata_o = order_word(step_tgt_q, word[15:8], word[7:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_o <= '0;  cnt_o <= '0;  dma_addr_o <= '0;  sel_q <= '0;
            busy_o <= 1'b0;  end_o <= 1'b0;  ready_o <= 1'b0;
            idle_flag_o <= 1'b1;  dte_n_o <= 1'b1;  irq5_o <= 1'b0;
            rd_valid_o <= 1'b0;  rd_data_o <= '0;  dma_done_o <= 1'b0;
            step_last_q <= 1'b0;  step_bank_q <= 1'b0;  step_tgt_q <= TGT_WSPLIT;
            step_off_q <= '0;  step_nw_q <= '0;
        end else begin
            irq5_o     <= 1'b0;
            rd_valid_o <= 1'b0;
            dma_done_o <= 1'b0;

            if (start_take) begin
                dac_o <= ld_dac_i;  cnt_o <= ld_cnt_i;  sel_q <= ld_sel_i;
                dma_addr_o <= ld_dma_addr_i;
                busy_o <= 1'b1;  ready_o <= 1'b1;
                end_o  <= 1'b0;  idle_flag_o <= 1'b0;
            end
            if (rd_take && !rd_ok) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= '0;
            end
            if (dma_take && !dma_ok) dma_done_o <= 1'b1;
            if (go_dma) begin
                step_last_q <= last_c;   step_nw_q  <= nw_c;
                step_tgt_q  <= route.tgt; step_bank_q <= route.bank;
                step_off_q  <= route.off;
            end
            if (commit_host) begin
                rd_valid_o <= 1'b1;
                rd_data_o  <= word;
                dac_o      <= dac_o + 16'd2;
                cnt_o      <= cnt_dec;
            end
            if (finish_dma) begin
                dma_done_o <= 1'b1;
                dac_o      <= dac_o + step_bytes;
                dma_addr_o <= dma_addr_o + adv;
                cnt_o      <= cnt_o - step_bytes;
            end
            if (do_end) begin
                cnt_o <= '0;  busy_o <= 1'b0;  end_o <= 1'b1;
                ready_o <= 1'b0;  idle_flag_o <= 1'b1;
                if (dte_ie_i) begin
                    dte_n_o <= 1'b0;
                    if (irq_mask5_i) irq5_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sbx_engine_chk.sv
module sbx_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        end_o,
    input logic        idle_flag_o,
    input logic        dte_n_o,
    input logic        irq5_o,
    input logic        dst_we_o,
    input logic        dte_ie_i,
    input logic        irq_mask5_i,
    input logic [15:0] cnt_o
);
    p_busy_end_excl_r4: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !end_o);

    p_idle_flag_r4: assert property (@(posedge clk) disable iff (rst)
        idle_flag_o == !busy_o);

    p_cnt_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(end_o) |-> cnt_o == 16'd0);

    p_we_busy_r10: assert property (@(posedge clk) disable iff (rst)
        dst_we_o |-> busy_o);

    p_irq_end_r5: assert property (@(posedge clk) disable iff (rst)
        irq5_o |-> (end_o && !dte_n_o));

    p_irq_mask_r5: assert property (@(posedge clk) disable iff (rst)
        irq5_o |-> $past(irq_mask5_i));

    p_dte_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(dte_n_o) |-> $past(dte_ie_i));
endmodule

bind sbx_engine sbx_engine_chk u_chk (
    .clk(clk), .rst(rst), .busy_o(busy_o), .end_o(end_o), .idle_flag_o(idle_flag_o),
    .dte_n_o(dte_n_o), .irq5_o(irq5_o), .dst_we_o(dst_we_o), .dte_ie_i(dte_ie_i),
    .irq_mask5_i(irq_mask5_i), .cnt_o(cnt_o)
);

// File: tb/sbx_engine_tb_top.sv
module sbx_engine_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, start_i, word_split_i, bank_mode_i, dte_ie_i, irq_mask5_i;
    logic [15:0] ld_dac_i, ld_cnt_i, ld_dma_addr_i;
    logic [2:0]  ld_sel_i;
    logic rd_i, rd_sub_i, rd_valid_o, dma_req_i, dma_done_o;
    logic [15:0] rd_data_o;
    logic [13:0] buf_addr_o;
    logic [7:0]  buf_rdata_i;
    logic dst_we_o, dst_bank_o;
    logic [1:0]  dst_tgt_o;
    logic [18:0] dst_addr_o;
    logic [15:0] dst_wdata_o, dac_o, cnt_o, dma_addr_o;
    logic busy_o, end_o, ready_o, idle_flag_o, dte_n_o, irq5_o;

    sbx_engine dut_i (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    function automatic logic [7:0] bf(input int a);
        logic [13:0] x;
        x = 14'(a);
        return 8'(x * 37) ^ {2'b00, x[13:8]};
    endfunction

    always_ff @(posedge clk) buf_rdata_i <= bf(int'(buf_addr_o));

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1; start_i = 0; rd_i = 0; rd_sub_i = 0; dma_req_i = 0;
        ld_dac_i = 0; ld_cnt_i = 0; ld_sel_i = 0; ld_dma_addr_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic do_start(input int dac, input int cnt, input int sel, input int dma);
        @(negedge clk);
        ld_dac_i = 16'(dac); ld_cnt_i = 16'(cnt); ld_sel_i = 3'(sel); ld_dma_addr_i = 16'(dma);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic host_read(input bit sub, output logic [15:0] d, output bit irq);
        int t;
        @(negedge clk);
        rd_i = 1; rd_sub_i = sub;
        @(negedge clk);
        rd_i = 0;
        t = 0;
        while (!rd_valid_o && t < 40) begin @(negedge clk); t++; end
        if (t >= 40) chk("R2 read timeout", 0, 1);
        d = rd_data_o; irq = irq5_o;
    endtask

    // One DMA step; checks every write against base offset and buffer bytes.
    task automatic dma_step(input int dac, input int base, input int kind, input bit bank,
                            output int nw, output bit irq);
        int t;
        logic [7:0] f, s;
        @(negedge clk);
        dma_req_i = 1;
        @(negedge clk);
        dma_req_i = 0;
        nw = 0; t = 0;
        forever begin
            if (dst_we_o) begin
                f = bf(dac + 2 * nw);
                s = bf(dac + 2 * nw + 1);
                chk("R7 dst addr", dst_addr_o, (base + 2 * nw) & 32'h7FFFF);
                chk("R8 dst data", dst_wdata_o, (kind == 3) ? {s, f} : {f, s});
                chk("R7 dst target", dst_tgt_o, kind);
                if (kind == 0) chk("R7 dst bank", dst_bank_o, bank);
                nw++;
            end
            if (dma_done_o || t > 2000) break;
            @(negedge clk); t++;
        end
        if (t > 2000) chk("R6 dma timeout", 0, 1);
        irq = irq5_o;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        bit irq;
        int nw;
        word_split_i = 0; bank_mode_i = 0; dte_ie_i = 0; irq_mask5_i = 0;
        do_reset();

        // R1 reset state
        chk("R1 busy", busy_o, 0);  chk("R1 end", end_o, 0);  chk("R1 ready", ready_o, 0);
        chk("R1 idle", idle_flag_o, 1);  chk("R1 dte_n", dte_n_o, 1);  chk("R1 irq", irq5_o, 0);
        chk("R1 dac", dac_o, 0);  chk("R1 cnt", cnt_o, 0);  chk("R1 dma", dma_addr_o, 0);

        // R3 read while not busy
        host_read(1, d, irq);
        chk("R3 idle read data", d, 0);  chk("R3 idle read dac", dac_o, 0);

        // R10 DMA while not busy
        dma_step(0, 0, 0, 0, nw, irq);
        chk("R10 idle dma writes", nw, 0);  chk("R10 idle dma cnt", cnt_o, 0);
        chk("R10 idle dma dac", dac_o, 0);

        // Host sweep over byte counts, interrupt enables and both readers
        for (int c = 0; c < 10; c++) begin
            int dac0, n, sel;
            bit sub, ie, mk;
            dac0 = (16'hFFF8 + c * 3) & 16'hFFFF;
            sel = (c % 2 == 1) ? 3 : 2;
            sub = (sel == 3);
            ie = c[0]; mk = c[1];
            do_reset();
            dte_ie_i = ie; irq_mask5_i = mk;
            do_start(dac0, c, sel, 0);
            chk("R11 busy", busy_o, 1);  chk("R11 ready", ready_o, 1);
            chk("R11 end", end_o, 0);  chk("R11 idle", idle_flag_o, 0);
            chk("R11 dac", dac_o, dac0);  chk("R11 cnt", cnt_o, c);
            host_read(!sub, d, irq);
            chk("R3 wrong side data", d, 0);  chk("R3 wrong side dac", dac_o, dac0);
            chk("R3 wrong side cnt", cnt_o, c);
            n = (c <= 0) ? 1 : (c + 1) / 2;
            for (int i = 0; i < n; i++) begin
                host_read(sub, d, irq);
                chk("R2 word", d, {bf(dac0 + 2 * i), bf(dac0 + 2 * i + 1)});
                chk("R2 dac step", dac_o, (dac0 + 2 * (i + 1)) & 16'hFFFF);
                if (i < n - 1) begin
                    chk("R2 cnt step", cnt_o, c - 2 * (i + 1));
                    chk("R4 still busy", busy_o, 1);
                    chk("R5 no early irq", irq, 0);
                end else begin
                    chk("R4 cnt zero", cnt_o, 0);  chk("R4 busy", busy_o, 0);
                    chk("R4 end", end_o, 1);  chk("R4 ready", ready_o, 0);
                    chk("R4 idle", idle_flag_o, 1);
                    chk("R5 irq", irq, ie & mk);  chk("R5 dte_n", dte_n_o, !ie);
                end
            end
            host_read(sub, d, irq);
            chk("R3 after end data", d, 0);
            chk("R3 after end dac", dac_o, (dac0 + 2 * n) & 16'hFFFF);
        end

        // R10 busy with a non-DMA selector
        do_reset();
        do_start(16'h0040, 100, 3, 16'h1234);
        dma_step(16'h0040, 0, 0, 0, nw, irq);
        chk("R10 sel3 writes", nw, 0);  chk("R10 sel3 dma", dma_addr_o, 16'h1234);
        chk("R10 sel3 cnt", cnt_o, 100);  chk("R10 sel3 dac", dac_o, 16'h0040);

        // DMA sweep over targets and byte counts
        for (int k = 0; k < 5; k++) begin
            for (int ci = 0; ci < 6; ci++) begin
                int counts[6] = '{1, 2, 7, 512, 513, 1030};
                int e_dac, e_cnt, e_dma, kind, sel, base, len, bytes;
                bit last, bank;
                kind = (k < 2) ? 0 : k - 1;
                sel  = (k < 3) ? 7 : (k == 3) ? 5 : 4;
                do_reset();
                word_split_i = (k < 2);
                bank_mode_i  = (k == 1);
                bank = (k != 1);
                dte_ie_i = 1; irq_mask5_i = 1;
                e_dac = (16'h3F00 + ci * 77) & 16'hFFFF;
                e_cnt = counts[ci];
                e_dma = 16'hC123 + ci * 8;
                do_start(e_dac, e_cnt, sel, e_dma);
                last = 0;
                while (!last) begin
                    if (e_cnt > 512) begin len = 256; last = 0; end
                    else begin len = (e_cnt > 0) ? (e_cnt + 1) / 2 : 0; last = 1; end
                    case (kind)
                        0: base = (e_dma & 16'h3FFF) << 3;
                        1: base = (e_dma & 16'h7FFF) << 3;
                        2: base = e_dma << 3;
                        default: base = (e_dma & 16'h03FF) << 2;
                    endcase
                    dma_step(e_dac, base, kind, bank, nw, irq);
                    chk("R6 word count", nw, len);
                    bytes = 2 * len;
                    e_dac = (e_dac + bytes) & 16'hFFFF;
                    e_dma = (e_dma + ((kind == 3) ? bytes / 4 : bytes / 8)) & 16'hFFFF;
                    e_cnt = last ? 0 : e_cnt - bytes;
                    chk("R9 dac", dac_o, e_dac);
                    chk("R9 dma addr", dma_addr_o, e_dma);
                    chk("R9 cnt", cnt_o, e_cnt);
                    chk("R6 busy", busy_o, !last);
                    chk("R5 dma irq", irq, last);
                end
                chk("R4 dma end", end_o, 1);
                chk("R4 dma idle", idle_flag_o, 1);
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule